// File: doc/BRIEF.md
# Cycle-Counting Interrupt Timer with Program Bank Select

This block sits on the CPU write path of a cartridge and gives the program two services: a free-running cycle counter that raises an interrupt when it wraps, and a switchable 16 KB program window. CPU writes anywhere in 0x8000–0xFFFF are decoded by the top address nibble into seven register regions. A 16-bit reload value is assembled from four nibble writes. A control write picks the counting width (the whole 16 bits, or only the low byte), starts or stops the count, and keeps a flag that decides whether counting resumes after the interrupt is acknowledged.

The counter advances on each cycle in which `cpu_tick` is high. When it sits at its wrap value on such a cycle, it is reloaded instead of incremented and the interrupt line goes high. The line stays high until software clears it. For CPU reads, `prg_bank` gives the program-memory bank to place above the 14 offset bits. The lower window 0x8000–0xBFFF follows the selected bank. The upper window 0xC000–0xFFFF always maps to the last bank.

Top module: `irq_bank_timer`

## Requirements
- R1: A write with address bits [15:12] of 0x8, 0x9, 0xA or 0xB loads `wr_data[3:0]` into reload bits [3:0], [7:4], [11:8] or [15:12] in that order. No other reload bit changes.
- R2: A write with address bits [15:12] = 0xC sets three flags from the data: bit 2 byte mode (1 = count the low 8 bits only), bit 1 run, bit 0 resume-after-acknowledge. The same write clears the interrupt.
- R3: When an 0xC write sets bit 1, the counter is loaded in that cycle. With bit 2 = 0 all 16 reload bits are copied. With bit 2 = 1 only the low byte is copied and the counter's high byte is kept.
- R4: A write with address bits [15:12] = 0xD clears the interrupt and copies the stored resume-after-acknowledge flag into the run flag, without loading the counter.
- R5: In 16-bit mode with run set, each tick adds one to the counter. A tick that finds 0xFFFF loads the full reload value instead and sets the interrupt on the next clock edge.
- R6: In byte mode with run set, each tick adds one to the low byte only. A tick that finds the low byte at 0xFF loads the reload low byte into it instead and sets the interrupt. The high byte never changes while counting.
- R7: The interrupt is a sticky level. Once high, it stays high through further ticks and wraps until an 0xC or 0xD write or a reset.
- R8: While run is clear, ticks leave the counter unchanged and the interrupt cannot be set.
- R9: A write with address bits [15:12] = 0xF stores `wr_data[3:0]` as the bank select. For `cpu_addr` in 0x8000–0xBFFF, `prg_bank` is the select modulo PRG_BANKS. For 0xC000–0xFFFF it is PRG_BANKS-1. Below 0x8000 it is 0.
- R10: A synchronous active-low reset clears the counter, the reload value, all three flags, the interrupt and the bank select.
- R11: A tick in the same cycle as an 0xC or 0xD write does not advance the counter. Writes with address bits [15:12] = 0xE, or below 0x8000, change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_tick | input | 1 | One CPU cycle has elapsed; advances the counter |
| wr_en | input | 1 | CPU write strobe for this clock |
| cpu_addr | input | 16 | CPU address, decoded for writes and for the read window |
| wr_data | input | 8 | CPU write data |
| irq | output | 1 | Active-high sticky interrupt request |
| prg_bank | output | BANK_W | Program bank for the current `cpu_addr` (combinational) |

## Verification
The assertions assume that `cpu_tick`, `wr_en`, `cpu_addr` and `wr_data` are stable around each rising edge. They also assume that a write presents its full region address in the same cycle as the strobe, so a control write and a tick can coincide but two writes cannot. The stimulus changes inputs only on falling edges and issues at most one write per clock. Some directed cycles deliberately pair a tick with an acknowledge write. A seeded random phase draws region nibbles across the whole 0x0–0xF range, including the unused 0xE region and low addresses.

// File: rtl/irqt_pkg.sv
// Package irqt_pkg
// Shared constants and types for the cycle-counting interrupt timer.
// Assumes a 16-bit CPU address and a 16-bit counter.
package irqt_pkg;

    localparam int CTR_W  = 16;
    localparam int LO_W   = 8;
    localparam int NIB_W  = 4;
    localparam int NIBS   = CTR_W / NIB_W;
    localparam int SEL_W  = 4;

    // Register regions, keyed by CPU address bits [15:12]
    localparam logic [3:0] RGN_RLD_BASE = 4'h8;
    localparam logic [3:0] RGN_CTRL     = 4'hC;
    localparam logic [3:0] RGN_ACK      = 4'hD;
    localparam logic [3:0] RGN_BANK     = 4'hF;

    // Control flags held by the register file
    typedef struct packed {
        logic byte_mode;
        logic run;
        logic run_after_ack;
    } ctl_t;

endpackage

// File: rtl/irqt_regs.sv
// Module irqt_regs
// Decodes CPU writes by address nibble and holds the reload value, the
// control flags and the bank select. Emits one-cycle pulses for control
// and acknowledge writes. Assumes at most one write per clock.
module irqt_regs
    import irqt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [15:0]        wr_addr,
    input  logic [7:0]         wr_data,
    output logic [CTR_W-1:0]   reload,
    output ctl_t               ctl,
    output logic [SEL_W-1:0]   bank_sel,
    output logic               ctl_wr,
    output logic               ack_wr,
    output logic               load_req,
    output logic               load_byte_mode
);

    logic [3:0] region;
    assign region = wr_addr[15:12];

    // Strobes for the control and acknowledge regions
    assign ctl_wr         = wr_en && (region == RGN_CTRL);
    assign ack_wr         = wr_en && (region == RGN_ACK);
    assign load_req       = ctl_wr && wr_data[1];
    assign load_byte_mode = wr_data[2];

    // One nibble register per reload slice, each with its own region
    for (genvar g = 0; g < NIBS; g++) begin : g_nib
        localparam logic [3:0] MY_RGN = RGN_RLD_BASE + 4'(g);

        // Load this reload nibble on a write to its region
        always_ff @(posedge clk) begin
            if (!rst_n)
                reload[g*NIB_W +: NIB_W] <= '0;
            else if (wr_en && region == MY_RGN)
                reload[g*NIB_W +: NIB_W] <= wr_data[NIB_W-1:0];
        end
    end

    // Control flags: full load on a control write, run reloaded on acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '0;
        end else if (ctl_wr) begin
            ctl.byte_mode     <= wr_data[2];
            ctl.run           <= wr_data[1];
            ctl.run_after_ack <= wr_data[0];
        end else if (ack_wr) begin
            ctl.run <= ctl.run_after_ack;
        end
    end

    // Bank select register
    always_ff @(posedge clk) begin
        if (!rst_n)
            bank_sel <= '0;
        else if (wr_en && region == RGN_BANK)
            bank_sel <= wr_data[SEL_W-1:0];
    end

    // R1
    rld_nib0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[15:12] == 4'h8) |=>
            (reload[3:0] == $past(wr_data[3:0])) && (reload[15:4] == $past(reload[15:4])));

    // R1
    rld_nib3_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[15:12] == 4'hB) |=>
            (reload[15:12] == $past(wr_data[3:0])) && (reload[11:0] == $past(reload[11:0])));

    // R2
    ctl_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> ({ctl.byte_mode, ctl.run, ctl.run_after_ack} == $past(wr_data[2:0])));

    // R4
    ack_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_wr |=> (ctl.run == $past(ctl.run_after_ack)) && $stable(ctl.run_after_ack));

    // R11
    unused_rgn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || wr_addr[15:12] == 4'hE || !wr_addr[15]) |=>
            $stable(reload) && $stable(ctl) && $stable(bank_sel));

endmodule

// File: rtl/irqt_counter.sv
// Module irqt_counter
// The 16-bit cycle counter and the sticky interrupt flag. Counts in full
// width or low byte only, reloading on wrap. Assumes load_req only comes
// with hold (both derive from a control write).
module irqt_counter
    import irqt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               run,
    input  logic               byte_mode,
    input  logic [CTR_W-1:0]   reload,
    input  logic               load_req,
    input  logic               load_byte_mode,
    input  logic               hold,
    input  logic               clr_irq,
    output logic               irq
);

    logic [CTR_W-1:0] count;
    logic [CTR_W-1:0] count_nxt;
    logic [LO_W-1:0]  lo_inc;
    logic             wrap_full;
    logic             wrap_lo;
    logic             wrap;
    logic             step;

    // Wrap detection and step qualification
    always_comb begin
        wrap_full = (count == {CTR_W{1'b1}});
        wrap_lo   = (count[LO_W-1:0] == {LO_W{1'b1}});
        wrap      = byte_mode ? wrap_lo : wrap_full;
        step      = tick && run && !hold;
        lo_inc    = count[LO_W-1:0] + 1'b1;
    end

    // Next counter value: explicit load, wrap reload, or increment
    always_comb begin
        count_nxt = count;
        if (load_req) begin
            if (load_byte_mode)
                count_nxt = {count[CTR_W-1:LO_W], reload[LO_W-1:0]};
            else
                count_nxt = reload;
        end else if (step) begin
            if (byte_mode)
                count_nxt = {count[CTR_W-1:LO_W], wrap ? reload[LO_W-1:0] : lo_inc};
            else
                count_nxt = wrap ? reload : count + 1'b1;
        end
    end

    // Counter register
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else
            count <= count_nxt;
    end

    // Sticky interrupt: set on a counted wrap, cleared by software writes
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else if (clr_irq)
            irq <= 1'b0;
        else if (step && wrap)
            irq <= 1'b1;
    end

    // R3
    byte_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_req && load_byte_mode) |=>
            (count[CTR_W-1:LO_W] == $past(count[CTR_W-1:LO_W])) &&
            (count[LO_W-1:0] == $past(reload[LO_W-1:0])));

    // R3
    full_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_req && !load_byte_mode) |=> (count == $past(reload)));

    // R5
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(tick && run && !hold));

    // R6
    hi_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_mode && !load_req) |=> (count[CTR_W-1:LO_W] == $past(count[CTR_W-1:LO_W])));

    // R7
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_irq) |=> irq);

    // R2
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_irq |=> !irq);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load_req) |=> ($stable(count) && ($past(irq) || !irq)));

    // R11
    hold_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !load_req) |=> $stable(count));

endmodule

// File: rtl/irqt_bankmap.sv
// Module irqt_bankmap
// Maps a CPU read address to a program-memory bank. The lower 16 KB
// window follows the bank select, the upper one is fixed to the last
// bank. Assumes PRG_BANKS is a power of two no smaller than 2.
module irqt_bankmap
    import irqt_pkg::*;
#(
    parameter int PRG_BANKS = 8,
    parameter int BANK_W    = $clog2(PRG_BANKS)
) (
    input  logic [SEL_W-1:0]  bank_sel,
    input  logic [1:0]        addr_hi,
    output logic [BANK_W-1:0] prg_bank
);

    localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(PRG_BANKS - 1);

    logic [BANK_W-1:0] sel_wrapped;

    // Fit the select to the installed bank count
    if (BANK_W <= SEL_W) begin : g_trim
        assign sel_wrapped = bank_sel[BANK_W-1:0];
    end else begin : g_pad
        assign sel_wrapped = {{(BANK_W-SEL_W){1'b0}}, bank_sel};
    end

    // Window select by CPU address bits [15:14]
    always_comb begin
        case (addr_hi)
            2'b10:   prg_bank = sel_wrapped;
            2'b11:   prg_bank = LAST_BANK;
            default: prg_bank = '0;
        endcase
    end

endmodule

// File: rtl/irq_bank_timer.sv
// Module irq_bank_timer
// Top of the cartridge cycle-counting interrupt timer with program bank
// select. Ties the write decoder, the counter and the read-window map
// together. Assumes one CPU write at most per clock and cpu_tick pulsing
// once per CPU cycle.
module irq_bank_timer
    import irqt_pkg::*;
#(
    parameter int PRG_BANKS = 8,
    parameter int BANK_W    = $clog2(PRG_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_tick,
    input  logic              wr_en,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        wr_data,
    output logic              irq,
    output logic [BANK_W-1:0] prg_bank
);

    logic [CTR_W-1:0] reload;
    ctl_t             ctl;
    logic [SEL_W-1:0] bank_sel;
    logic             ctl_wr;
    logic             ack_wr;
    logic             load_req;
    logic             load_byte_mode;
    logic             sw_touch;

    // Either software write region stalls the count and drops the interrupt
    assign sw_touch = ctl_wr || ack_wr;

    irqt_regs u_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (wr_en),
        .wr_addr        (cpu_addr),
        .wr_data        (wr_data),
        .reload         (reload),
        .ctl            (ctl),
        .bank_sel       (bank_sel),
        .ctl_wr         (ctl_wr),
        .ack_wr         (ack_wr),
        .load_req       (load_req),
        .load_byte_mode (load_byte_mode)
    );

    irqt_counter u_ctr (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick           (cpu_tick),
        .run            (ctl.run),
        .byte_mode      (ctl.byte_mode),
        .reload         (reload),
        .load_req       (load_req),
        .load_byte_mode (load_byte_mode),
        .hold           (sw_touch),
        .clr_irq        (sw_touch),
        .irq            (irq)
    );

    irqt_bankmap #(
        .PRG_BANKS (PRG_BANKS),
        .BANK_W    (BANK_W)
    ) u_map (
        .bank_sel (bank_sel),
        .addr_hi  (cpu_addr[15:14]),
        .prg_bank (prg_bank)
    );

    // R9
    low_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:14] == 2'b10) |-> (prg_bank == BANK_W'(bank_sel % PRG_BANKS)));

    // R9
    fixed_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:14] == 2'b11) |-> (prg_bank == BANK_W'(PRG_BANKS - 1)));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!irq && bank_sel == '0 && reload == '0));

endmodule

// File: tb/sim_irq_bank_timer.sv
module sim_irq_bank_timer;

    localparam int PRG_BANKS = 8;
    localparam int BANK_W    = $clog2(PRG_BANKS);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cpu_tick = 1'b0;
    logic              wr_en = 1'b0;
    logic [15:0]       cpu_addr = 16'h0;
    logic [7:0]        wr_data = 8'h0;
    logic              irq;
    logic [BANK_W-1:0] prg_bank;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Behavioural model state
    int m_ctr = 0, m_rld = 0, m_sel = 0;
    bit m_run = 0, m_byte = 0, m_ae = 0, m_irq = 0;

    always #2 clk = ~clk;

    irq_bank_timer #(.PRG_BANKS(PRG_BANKS)) u0 (
        .clk(clk), .rst_n(rst_n), .cpu_tick(cpu_tick), .wr_en(wr_en),
        .cpu_addr(cpu_addr), .wr_data(wr_data), .irq(irq), .prg_bank(prg_bank)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_bank(input int a);
        if (a >= 16'hC000) return PRG_BANKS - 1;
        if (a >= 16'h8000) return m_sel % PRG_BANKS;
        return 0;
    endfunction

    // Reference model, advanced on every rising edge from the sampled inputs
    always @(posedge clk) begin : model
        int rg, nc, d;
        bit ni, hold;
        if (!rst_n) begin
            m_ctr = 0; m_rld = 0; m_sel = 0;
            m_run = 0; m_byte = 0; m_ae = 0; m_irq = 0;
        end else begin
            rg = int'(cpu_addr) / 4096;
            d  = int'(wr_data);
            nc = m_ctr; ni = m_irq;
            hold = wr_en && (rg == 12 || rg == 13);
            if (cpu_tick && m_run && !hold) begin
                if (m_byte) begin
                    if (m_ctr % 256 == 255) begin
                        nc = (m_ctr / 256) * 256 + m_rld % 256; ni = 1;
                    end else nc = m_ctr + 1;
                end else begin
                    if (m_ctr == 65535) begin nc = m_rld; ni = 1; end
                    else nc = m_ctr + 1;
                end
            end
            if (wr_en) begin
                if (rg >= 8 && rg <= 11) begin
                    int sh;
                    sh = 1 << (4 * (rg - 8));
                    m_rld = m_rld - ((m_rld / sh) % 16) * sh + (d % 16) * sh;
                end else if (rg == 12) begin
                    m_byte = d[2]; m_run = d[1]; m_ae = d[0]; ni = 0;
                    if (d[1]) nc = d[2] ? (m_ctr / 256) * 256 + m_rld % 256 : m_rld;
                end else if (rg == 13) begin
                    m_run = m_ae; ni = 0;
                end else if (rg == 15) begin
                    m_sel = d % 16;
                end
            end
            m_ctr = nc; m_irq = ni;
        end
    end

    // Per-clock comparison against the model, away from the edge
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            chk(irq == m_irq, m_byte ? "R6 model irq" : "R5 model irq", irq, m_irq);
            chk(int'(prg_bank) == exp_bank(int'(cpu_addr)), "R9 model bank",
                prg_bank, exp_bank(int'(cpu_addr)));
        end
    end

    task automatic step(input bit t, input bit w, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_tick = t; wr_en = w; cpu_addr = a; wr_data = d;
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        step(1'b0, 1'b1, a, d);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 16'h0, 8'h0);
    endtask

    task automatic set_reload(input logic [15:0] v);
        wr(16'h8000, {4'h0, v[3:0]});
        wr(16'h9000, {4'h0, v[7:4]});
        wr(16'hA000, {4'h0, v[11:8]});
        wr(16'hB000, {4'h0, v[15:12]});
    endtask

    task automatic until_irq(input int lim, output int n);
        n = 0;
        while (!irq && n < lim) begin
            step(1'b1, 1'b0, 16'h0, 8'h0);
            n++;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; cpu_tick = 0; wr_en = 0; cpu_addr = 0; wr_data = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    initial begin : watchdog
        #(4 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        int n;
        do_reset();

        // R10: reset state at the ports
        step(1'b0, 1'b0, 16'h8000, 8'h0);
        chk(irq == 1'b0, "R10 irq after reset", irq, 0);
        chk(prg_bank == 0, "R10 bank after reset", prg_bank, 0);
        step(1'b0, 1'b0, 16'hC000, 8'h0);
        chk(prg_bank == PRG_BANKS - 1, "R9 fixed window", prg_bank, PRG_BANKS - 1);
        // R10: reload cleared -> byte mode from 0x00 wraps after 256 ticks
        wr(16'hC000, 8'h06);
        until_irq(400, n);
        chk(n == 256, "R10 reload zero period", n, 256);
        wr(16'hC000, 8'h00);
        chk(irq == 1'b0, "R2 control write clears irq", irq, 0);

        // R1/R5: 16-bit count from 0xFFF0
        set_reload(16'hFFF0);
        wr(16'hC000, 8'h02);
        until_irq(100, n);
        chk(n == 16, "R1 R5 16-bit period", n, 16);

        // R7: sticky through further wraps
        ticks(40);
        chk(irq == 1'b1, "R7 irq sticky", irq, 1);

        // R4/R8: acknowledge with resume clear stops counting
        wr(16'hD000, 8'h00);
        chk(irq == 1'b0, "R4 ack clears irq", irq, 0);
        ticks(60);
        chk(irq == 1'b0, "R8 stopped counter no irq", irq, 0);

        // R6/R11: byte mode from 0xF8 with ignored writes mixed in
        wr(16'h8000, 8'h08);
        wr(16'h9000, 8'h0F);
        wr(16'hC000, 8'h07);
        ticks(3);
        wr(16'hE000, 8'hFF);
        wr(16'h7000, 8'h07);
        wr(16'h0C00, 8'h02);
        until_irq(100, n);
        chk(n == 5, "R11 R6 ignored writes, byte period", n, 5);

        // R4: acknowledge with resume set keeps counting
        wr(16'hD000, 8'h00);
        chk(irq == 1'b0, "R4 ack clears irq", irq, 0);
        until_irq(100, n);
        chk(n == 8, "R4 resume after ack", n, 8);

        // R3: byte-mode load keeps the high byte
        set_reload(16'hFFE0);
        wr(16'hC000, 8'h02);
        ticks(4);
        set_reload(16'h00FC);
        wr(16'hC000, 8'h06);
        ticks(2);
        chk(irq == 1'b0, "R3 no early irq", irq, 0);
        wr(16'hC000, 8'h01);
        wr(16'hD000, 8'h00);
        until_irq(100, n);
        chk(n == 2, "R3 high byte kept", n, 2);

        // R11: tick coinciding with an ack write is dropped
        wr(16'hC000, 8'h07);
        step(1'b1, 1'b1, 16'hD000, 8'h00);
        until_irq(100, n);
        chk(n == 4, "R11 tick during ack suppressed", n, 4);

        // R9: bank select and wrap to installed size
        wr(16'hF000, 8'h05);
        step(1'b0, 1'b0, 16'h8000, 8'h0);
        chk(prg_bank == 5, "R9 lower window", prg_bank, 5);
        wr(16'hF000, 8'h0B);
        step(1'b0, 1'b0, 16'hBFFF, 8'h0);
        chk(prg_bank == 3, "R9 select wraps", prg_bank, 3);
        step(1'b0, 1'b0, 16'hFFFF, 8'h0);
        chk(prg_bank == PRG_BANKS - 1, "R9 upper window fixed", prg_bank, PRG_BANKS - 1);
        step(1'b0, 1'b0, 16'h4000, 8'h0);
        chk(prg_bank == 0, "R9 below program space", prg_bank, 0);

        // Seeded mixed traffic, compared against the model each clock
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            if (r < 15)
                step(1'($urandom_range(0, 1)), 1'b1,
                     {4'($urandom_range(0, 15)), 12'h0}, 8'($urandom_range(0, 255)));
            else
                step(1'b1, 1'b0, 16'h8000, 8'h0);
        end

        // R10: reset mid-run
        do_reset();
        step(1'b0, 1'b0, 16'h8000, 8'h0);
        chk(irq == 1'b0, "R10 irq after second reset", irq, 0);
        chk(prg_bank == 0, "R10 bank after second reset", prg_bank, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule